// File: doc/BRIEF.md
# BPSK Tag Response Frame Transmitter

This block turns a tag's response into a stream of subcarrier phase decisions, one decision per half bit time. Given a byte count, a CRC-disable flag and an encoding select, a start pulse makes it emit a fixed preamble. The data bytes follow as framed characters, then an optional two-byte CRC_B, then a closing sequence, after which the subcarrier is switched off and a one-cycle done pulse is raised. The carrier, the subcarrier oscillator and the load modulator sit outside; they consume `sc_en` (subcarrier on) and `phase` (0 or 180 degrees).

Timing comes from an external `half_tick` strobe, one clock wide, that marks every half bit time. The response must begin a fixed 12 bit times after the reader's end-of-frame marker starts. The controller that measures that gap raises `start`, and the first half symbol then goes out on the next strobe. Bytes are pulled one at a time: `byte_in` holds the next byte, and the block signals with `byte_take` each time it has latched one.

Two phase codings are offered. With NRZ-L, the phase follows the level and flips on every change of bit value. With Miller, a 1 flips the phase in mid-bit and a run of 0s flips it at the start of each bit after the first. The two codings differ at the seam between preamble and first start bit.

Top module: `bpsk_resp_tx`

## Requirements
- R1: After reset and between frames, `sc_en`, `phase`, `done` and `byte_take` are all 0.
- R2: A `start` seen while idle latches `byte_cnt` (at least 1), `crc_off` and `miller`. `sc_en` rises in the clock after the first `half_tick` that follows the latching edge. A `start` during a frame has no effect on that frame.
- R3: The preamble is 44 half symbols: 20 at phase 0, then 20 at phase 1, then 4 at phase 0.
- R4: Each character is 11 bits (22 half symbols): a 0 start bit, the 8 byte bits least significant first, a 1 stop bit and a 1 guard bit. Data bytes go out in order. `byte_take` pulses exactly once per data byte. `byte_in` is latched in the half tick that opens the byte's start bit, and it must show the next byte from the clock after each `byte_take` pulse.
- R5: With `miller`=0 (NRZ-L), both halves of a bit carry the same phase, and the phase flips exactly when the bit value differs from the previous bit. The bit before the first start bit counts as 1, so the first start bit is at phase 1.
- R6: With `miller`=1, a 1 flips the phase between its halves. A 0 after a 0 flips the phase at its start. A 0 after a 1 does not flip. The bit before the first start bit counts as 1, so the first start bit stays at phase 0.
- R7: Unless `crc_off`=1, two CRC characters follow the data. The CRC is the bit-reflected 0x1021 CRC (0x8408 shifted LSB first), starts from 0xFFFF, covers only the data bits and is inverted before sending, low byte first. With `crc_off`=1 no CRC characters are sent.
- R8: The closing sequence is 10 bits of 0 then 2 bits of 1 in the selected coding. On the next `half_tick`, `sc_en` and `phase` drop to 0 and `done` pulses for exactly one clock.
- R9: `phase` and `sc_en` change only in the clock right after a `half_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-clock strobe per half bit time |
| start | input | 1 | Begin a response frame (honoured only when idle) |
| byte_cnt | input | CNT_W | Number of data bytes, 1 or more |
| crc_off | input | 1 | 1 omits the CRC characters |
| miller | input | 1 | 0 selects NRZ-L phase coding, 1 selects Miller |
| byte_in | input | 8 | Next data byte to send |
| byte_take | output | 1 | One-clock pulse: current `byte_in` has been latched |
| sc_en | output | 1 | Subcarrier enable |
| phase | output | 1 | Subcarrier phase, 0 or 180 degrees |
| done | output | 1 | One-clock pulse when the frame has ended |

## Verification
The assertions assume that `byte_cnt` is nonzero whenever `start` arrives while the subcarrier is off. They also assume that `half_tick` is a strobe in the sense that output changes are judged against it, so the checks on output stability are stated relative to the previous clock's strobe. The stimulus keeps to this: it never starts a frame with a zero count, and it drives `half_tick` from a fixed divide-by-four counter so that strobes never sit on adjacent clocks. It advances `byte_in` from `byte_take` well before the next start bit. The one `start` raised during a frame comes with a different count and coding, so any leak into the running frame shows up in the decoded phase stream.

// File: rtl/bpsk_tx_pkg.sv
package bpsk_tx_pkg;

    localparam int SOT_LONG_BITS  = 10;
    localparam int SOT_SHORT_BITS = 2;
    localparam int EOT_LOW_BITS   = 10;
    localparam int EOT_HIGH_BITS  = 2;
    localparam int CHAR_BITS      = 11;
    localparam int CRC_BYTES      = 2;

    localparam int SOT_HALVES     = 2 * (2 * SOT_LONG_BITS + SOT_SHORT_BITS);
    localparam int SOT_FLIP_A     = 2 * SOT_LONG_BITS;
    localparam int SOT_FLIP_B     = 4 * SOT_LONG_BITS;
    localparam int EOT_BITS       = EOT_LOW_BITS + EOT_HIGH_BITS;

    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_SEED      = 16'hFFFF;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SOT,
        TX_CHAR,
        TX_EOT,
        TX_TAIL
    } tx_state_e;

endpackage

// File: rtl/bpsk_crc_b.sv
module bpsk_crc_b #(
    parameter logic [15:0] POLY = bpsk_tx_pkg::CRC_POLY_REFL,
    parameter logic [15:0] SEED = bpsk_tx_pkg::CRC_SEED
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = SEED;
        end else if (en) begin
            crc_d = (crc_q >> 1) ^ ((crc_q[0] ^ din) ? POLY : 16'h0000);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= SEED;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/bpsk_phase_enc.sv
module bpsk_phase_enc (
    input  logic miller,
    input  logic second_half,
    input  logic bit_v,
    input  logic prev_bit,
    input  logic ph_cur,
    output logic ph_next
);

    logic flip;

    always_comb begin
        if (miller) begin
            flip = second_half ? bit_v : (!bit_v && !prev_bit);
        end else begin
            flip = second_half ? 1'b0 : (bit_v ^ prev_bit);
        end
        ph_next = ph_cur ^ flip;
    end

endmodule

// File: rtl/bpsk_resp_tx.sv
module bpsk_resp_tx #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             crc_off,
    input  logic             miller,
    input  logic [7:0]       byte_in,
    output logic             byte_take,
    output logic             sc_en,
    output logic             phase,
    output logic             done
);
    import bpsk_tx_pkg::*;

    localparam int HC_W = $clog2(SOT_HALVES);
    localparam int BP_W = $clog2(CHAR_BITS);
    localparam int EC_W = $clog2(EOT_BITS);
    localparam int CI_W = CNT_W + 1;

    localparam logic [HC_W-1:0] HC_LAST  = HC_W'(SOT_HALVES - 1);
    localparam logic [HC_W-1:0] HC_FLIPA = HC_W'(SOT_FLIP_A);
    localparam logic [HC_W-1:0] HC_FLIPB = HC_W'(SOT_FLIP_B);
    localparam logic [BP_W-1:0] BP_LAST  = BP_W'(CHAR_BITS - 1);
    localparam logic [EC_W-1:0] EC_LAST  = EC_W'(EOT_BITS - 1);
    localparam logic [EC_W-1:0] EC_HIGH  = EC_W'(EOT_LOW_BITS);
    localparam logic [CI_W-1:0] CI_CRC   = CI_W'(CRC_BYTES);

    typedef struct packed {
        tx_state_e        st;
        logic [HC_W-1:0]  hcnt;
        logic             half;
        logic [BP_W-1:0]  bpos;
        logic [CI_W-1:0]  cidx;
        logic [EC_W-1:0]  ecnt;
        logic [CNT_W-1:0] nbytes;
        logic             coff;
        logic             mil;
        logic [7:0]       shreg;
        logic             curb;
        logic             prevb;
        logic             ph;
        logic             sc;
        logic             done;
        logic             take;
    } tx_regs_t;

    tx_regs_t d, q;

    logic        crc_clr, crc_en, crc_din;
    logic [15:0] crc_val;
    logic        bit_now, enc_bit, ph_enc;
    logic        data_bit_pos;
    logic [CI_W-1:0] total_chars;
    logic [CI_W-1:0] nbytes_ext;
    logic [2:0]  bit_sel;

    bpsk_crc_b u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc_val)
    );

    bpsk_phase_enc u_enc (
        .miller      (q.mil),
        .second_half (q.half),
        .bit_v       (enc_bit),
        .prev_bit    (q.prevb),
        .ph_cur      (q.ph),
        .ph_next     (ph_enc)
    );

    // Bit value presented in the current bit slot.
    always_comb begin
        bit_sel      = q.bpos[2:0] - 3'd1;
        data_bit_pos = (q.bpos != '0) && (q.bpos <= BP_W'(8));
        nbytes_ext   = {1'b0, q.nbytes};
        total_chars  = q.coff ? nbytes_ext : (nbytes_ext + CI_CRC);
        if (q.st == TX_EOT) begin
            bit_now = (q.ecnt >= EC_HIGH);
        end else if (q.bpos == '0) begin
            bit_now = 1'b0;
        end else if (data_bit_pos) begin
            bit_now = q.shreg[bit_sel];
        end else begin
            bit_now = 1'b1;
        end
        enc_bit = q.half ? q.curb : bit_now;
    end

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.take  = 1'b0;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        crc_din = bit_now;
        unique case (q.st)
            TX_IDLE: begin
                if (start) begin
                    d.st     = TX_SOT;
                    d.nbytes = byte_cnt;
                    d.coff   = crc_off;
                    d.mil    = miller;
                    d.hcnt   = '0;
                    d.prevb  = 1'b1;
                    d.ph     = 1'b0;
                    crc_clr  = 1'b1;
                end
            end
            TX_SOT: begin
                if (half_tick) begin
                    d.sc = 1'b1;
                    d.ph = (q.hcnt >= HC_FLIPA) && (q.hcnt < HC_FLIPB);
                    if (q.hcnt == HC_LAST) begin
                        d.st   = TX_CHAR;
                        d.half = 1'b0;
                        d.bpos = '0;
                        d.cidx = '0;
                    end else begin
                        d.hcnt = q.hcnt + 1'b1;
                    end
                end
            end
            TX_CHAR, TX_EOT: begin
                if (half_tick) begin
                    d.ph = ph_enc;
                    if (!q.half) begin
                        d.curb = bit_now;
                        d.half = 1'b1;
                        if (q.st == TX_CHAR && q.bpos == '0) begin
                            if (q.cidx < nbytes_ext) begin
                                d.shreg = byte_in;
                                d.take  = 1'b1;
                            end else if (q.cidx == nbytes_ext) begin
                                d.shreg = ~crc_val[7:0];
                            end else begin
                                d.shreg = ~crc_val[15:8];
                            end
                        end
                        if (q.st == TX_CHAR && data_bit_pos && q.cidx < nbytes_ext) begin
                            crc_en = 1'b1;
                        end
                    end else begin
                        d.prevb = q.curb;
                        d.half  = 1'b0;
                        if (q.st == TX_CHAR) begin
                            if (q.bpos == BP_LAST) begin
                                d.bpos = '0;
                                if (q.cidx + 1'b1 == total_chars) begin
                                    d.st   = TX_EOT;
                                    d.ecnt = '0;
                                end else begin
                                    d.cidx = q.cidx + 1'b1;
                                end
                            end else begin
                                d.bpos = q.bpos + 1'b1;
                            end
                        end else begin
                            if (q.ecnt == EC_LAST) d.st = TX_TAIL;
                            else                   d.ecnt = q.ecnt + 1'b1;
                        end
                    end
                end
            end
            TX_TAIL: begin
                if (half_tick) begin
                    d.sc   = 1'b0;
                    d.ph   = 1'b0;
                    d.done = 1'b1;
                    d.st   = TX_IDLE;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= TX_IDLE;
            q.prevb <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_take = q.take;
    assign sc_en     = q.sc;
    assign phase     = q.ph;
    assign done      = q.done;

endmodule

// File: rtl/bpsk_resp_tx_chk.sv
module bpsk_resp_tx_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             half_tick,
    input logic             start,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             byte_take,
    input logic             sc_en,
    input logic             phase,
    input logic             done
);

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(phase));

    // R9
    scen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(sc_en));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(sc_en));

    // R1
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_en |-> !phase);

    // R4
    take_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> sc_en);

    // R2
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !sc_en) |-> (byte_cnt != '0));

endmodule

bind bpsk_resp_tx bpsk_resp_tx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .start     (start),
    .byte_cnt  (byte_cnt),
    .byte_take (byte_take),
    .sc_en     (sc_en),
    .phase     (phase),
    .done      (done)
);

// File: tb/tb_bpsk_resp_tx.sv
`timescale 1ns/1ps
module tb_bpsk_resp_tx;

    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_tick;
    logic start = 1'b0;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic crc_off = 1'b0;
    logic miller = 1'b0;
    logic [7:0] byte_in;
    logic byte_take, sc_en, phase, done;

    always #2 clk = ~clk;

    bpsk_resp_tx #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .start(start),
        .byte_cnt(byte_cnt), .crc_off(crc_off), .miller(miller),
        .byte_in(byte_in), .byte_take(byte_take), .sc_en(sc_en),
        .phase(phase), .done(done)
    );

    logic [1:0] div = 2'd0;
    int cyc = 0;
    int take_cnt = 0;
    int take_base = 0;
    int byte_idx;
    logic [7:0] mem [8];

    assign half_tick = rst_n && (div == 2'd0);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) div <= div + 2'd1;
        if (rst_n && byte_take) take_cnt <= take_cnt + 1;
    end

    always_comb begin
        byte_idx = take_cnt - take_base;
        byte_in  = mem[byte_idx[2:0]];
    end

    // Scoreboard of expected half symbols.
    logic exp_q [$];

    int tb_checks = 0, tb_errs = 0;
    int mon_checks = 0, mon_errs = 0;
    int cur_n = 0;
    logic cur_coff = 1'b0, cur_mil = 1'b0;

    // Monitor state
    int done_cnt = 0;
    int rise_cyc = 0;
    int stab_total = 0;
    int hidx = 0;
    int mism = 0;
    int first_bad = 0;
    logic first_act = 1'b0, first_exp = 1'b0;
    logic last_ph = 1'b0;
    logic sc_prev = 1'b0;
    int extra = 0;

    function automatic string region_tag(int idx);
        int chars;
        int ch;
        chars = cur_n + (cur_coff ? 0 : 2);
        if (idx < 44) return "R3";
        if (idx >= 44 + 22 * chars) return "R8";
        ch = (idx - 44) / 22;
        if (ch >= cur_n) return "R7";
        return cur_mil ? "R6" : "R5";
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (sc_en && !sc_prev) begin
                rise_cyc = cyc;
                hidx = 0;
                mism = 0;
                extra = 0;
            end
            if (sc_en && div == 2'd1) begin
                if (exp_q.size() == 0) begin
                    extra++;
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    if (phase !== e) begin
                        if (mism == 0) begin
                            first_bad = hidx;
                            first_act = phase;
                            first_exp = e;
                        end
                        mism++;
                    end
                end
                last_ph = phase;
                hidx++;
            end else if (sc_en && sc_prev && phase !== last_ph) begin
                stab_total++;
            end
            if (done) begin
                mon_checks++;
                if (mism != 0) begin
                    mon_errs++;
                    $display("FAIL %s: half symbol %0d phase actual=%0b expected=%0b",
                             region_tag(first_bad), first_bad, first_act, first_exp);
                end
                mon_checks++;
                if (extra != 0 || exp_q.size() != 0) begin
                    mon_errs++;
                    $display("FAIL R8: frame length actual=%0d expected=%0d halves",
                             hidx, hidx - extra + exp_q.size());
                    exp_q.delete();
                end
                done_cnt++;
            end
            sc_prev = sc_en;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        tb_checks++;
        if (!ok) begin
            tb_errs++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_ref(int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ mem[i][b];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return ~c;
    endfunction

    task automatic push_expected(int n, logic coff, logic mil);
        logic ph;
        logic prev;
        logic [15:0] crc;
        int chars;
        logic bits [$];
        ph = 1'b0;
        prev = 1'b1;
        crc = crc_ref(n);
        chars = n + (coff ? 0 : 2);
        for (int i = 0; i < 20; i++) exp_q.push_back(1'b0);
        for (int i = 0; i < 20; i++) exp_q.push_back(1'b1);
        for (int i = 0; i < 4; i++)  exp_q.push_back(1'b0);
        for (int c = 0; c < chars; c++) begin
            logic [7:0] v;
            if (c < n)       v = mem[c];
            else if (c == n) v = crc[7:0];
            else             v = crc[15:8];
            bits.push_back(1'b0);
            for (int b = 0; b < 8; b++) bits.push_back(v[b]);
            bits.push_back(1'b1);
            bits.push_back(1'b1);
        end
        for (int i = 0; i < 10; i++) bits.push_back(1'b0);
        for (int i = 0; i < 2; i++)  bits.push_back(1'b1);
        foreach (bits[k]) begin
            logic b;
            b = bits[k];
            if (mil) begin
                if (!b && !prev) ph = ~ph;
                exp_q.push_back(ph);
                if (b) ph = ~ph;
                exp_q.push_back(ph);
            end else begin
                if (b != prev) ph = ~ph;
                exp_q.push_back(ph);
                exp_q.push_back(ph);
            end
            prev = b;
        end
    endtask

    task automatic run_frame(int n, logic coff, logic mil, int pat, bit poke);
        int d0, j, ce, dbase, tbase, sbase, waited;
        for (int i = 0; i < 8; i++) begin
            case (pat)
                0: mem[i] = 8'hA5 ^ 8'(i * 8'h5B);
                1: mem[i] = (i % 2 == 0) ? 8'h00 : 8'hFF;
                2: mem[i] = 8'(i * 8'h29 + 1);
                default: mem[i] = (i == 2) ? 8'h80 : 8'h00;
            endcase
        end
        cur_n = n;
        cur_coff = coff;
        cur_mil = mil;
        push_expected(n, coff, mil);
        @(negedge clk);
        take_base = take_cnt;
        tbase = take_cnt;
        dbase = done_cnt;
        sbase = stab_total;
        byte_cnt = CNT_W'(n);
        crc_off = coff;
        miller = mil;
        start = 1'b1;
        d0 = int'(div);
        @(negedge clk);
        ce = cyc;
        start = 1'b0;
        j = (d0 == 0) ? 4 : 4 - d0;
        if (poke) begin
            repeat (300) @(negedge clk);
            byte_cnt = CNT_W'(2);
            miller = ~mil;
            crc_off = ~coff;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == dbase && waited < 6000) begin
            @(negedge clk);
            waited++;
        end
        check(done_cnt != dbase, "R8", "done seen", done_cnt - dbase, 1);
        check(rise_cyc - ce == j, "R2", "cycles from start latch to sc_en", rise_cyc - ce, j);
        check(take_cnt - tbase == n, "R4", "byte_take pulses", take_cnt - tbase, n);
        check(stab_total == sbase, "R9", "phase changes between ticks", stab_total - sbase, 0);
        check(!sc_en && !phase && !byte_take, "R1", "idle outputs after frame",
              int'({sc_en, phase, byte_take}), 0);
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!sc_en && !phase && !done && !byte_take, "R1", "outputs in reset",
              int'({sc_en, phase, done, byte_take}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!sc_en && !phase && !done && !byte_take, "R1", "outputs after reset",
              int'({sc_en, phase, done, byte_take}), 0);
        run_frame(4, 1'b0, 1'b0, 0, 1'b0);   // R5 R7
        run_frame(4, 1'b0, 1'b1, 0, 1'b0);   // R6 R7
        run_frame(1, 1'b1, 1'b0, 1, 1'b0);   // R5, no CRC
        run_frame(1, 1'b1, 1'b1, 3, 1'b0);   // R6 zero run
        run_frame(7, 1'b0, 1'b1, 2, 1'b1);   // R2 busy start ignored
        run_frame(6, 1'b1, 1'b0, 1, 1'b0);   // R4 alternating bytes
        run_frame(3, 1'b0, 1'b1, 3, 1'b0);   // R6 R7
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", tb_errs + mon_errs, tb_checks + mon_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d cycles", 150000, 0);
        $display("Result: errors=%0d of %0d checks", tb_errs + mon_errs + 1,
                 tb_checks + mon_checks + 1);
        $finish;
    end

endmodule